// File: doc/BRIEF.md
# Console UART Register Front-End

This block is a memory-mapped character console for a processor. On a 32-bit Wishbone slave port it offers two words: a data word and a control word. Software sends a character by writing the data word. The character then waits in a transmit FIFO until a byte-stream host port takes it. Software receives a character by reading the data word. That read returns the oldest character held in a receive FIFO, together with a flag saying whether a character was there.

Software polls the control word to find how many transmit slots are free, and writes only while that number is above zero. The far side of both FIFOs is a plain byte-stream host port with valid/ready handshakes, standing in for a debug-link transport. A single parameter, `BUF_AW`, sizes the internal buffer. It is split evenly, so each direction holds 2^(BUF_AW-1) characters.

Top module: `con_uart_regs`

## Requirements
- R1: While `rst` is high at a clock edge, both FIFOs are emptied and `bus_ack` is cleared. Afterwards `htx_valid` is 0, `hrx_ready` is 1, the control word reads free = 2^(BUF_AW-1), and the data word reads 0.
- R2: For each access (`bus_cyc` and `bus_stb` high), `bus_ack` rises in the cycle after the request is seen and stays high for exactly one cycle. Read data is valid while `bus_ack` is high.
- R3: `bus_adr` = 0 selects the data word; `bus_adr` = 1 selects the control word (byte offset 4).
- R4: A write to the data word queues bits 7:0 of `bus_wdat` as one character. Bits 31:8 are ignored. Characters leave on `htx_data` in the order they were written.
- R5: A read of the control word returns the free transmit entries in bits 31:16 and zero in bits 15:0.
- R6: A data write while the transmit FIFO is full is dropped, and the control word then reads free = 0.
- R7: A data read with the receive FIFO non-empty returns the oldest character in bits 7:0, bit 15 = 1, all other bits 0, and removes that character.
- R8: A data read with the receive FIFO empty returns all zeros (bit 15 = 0) and changes no state.
- R9: `hrx_ready` is 1 exactly when the receive FIFO is not full. A character on `hrx_data` is stored at a clock edge where `hrx_wr` and `hrx_ready` are both 1; a strobe while full is ignored.
- R10: `htx_valid` is 1 while the transmit FIFO holds a character. `htx_data` shows its head and holds it until an edge with `htx_ready` high, which removes it.
- R11: Each FIFO holds 2^(BUF_AW-1) characters. `BUF_AW` outside 2..16 stops elaboration.
- R12: A write to the control word has no effect on either FIFO or on any later read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_cyc | input | 1 | Bus cycle |
| bus_stb | input | 1 | Bus strobe |
| bus_we | input | 1 | Bus write enable |
| bus_adr | input | 1 | Word select: 0 data, 1 control |
| bus_wdat | input | DW | Bus write data |
| bus_rdat | output | DW | Bus read data |
| bus_ack | output | 1 | Bus acknowledge, one cycle per access |
| htx_data | output | 8 | Head character of transmit FIFO |
| htx_valid | output | 1 | Transmit FIFO holds a character |
| htx_ready | input | 1 | Host takes the head character |
| hrx_data | input | 8 | Character to inject into receive FIFO |
| hrx_wr | input | 1 | Inject strobe |
| hrx_ready | output | 1 | Receive FIFO has room |

## Verification
The bench builds the block with `BUF_AW` = 3, which gives four entries per direction. Both FIFOs can therefore be filled in a handful of accesses, which brings within reach the dropped write at full, free = 0 in the control word, the deasserted inject ready, and the wrap of the pointers. The transmit drain is run twice: once with a sink that is always ready, and once with a sink that is ready every other cycle. These two runs exercise the hold of the head character under back-pressure.

// File: rtl/con_uart_pkg.sv
package con_uart_pkg;
   localparam int CHAR_W    = 8;
   localparam int VALID_BIT = 15;
   localparam int FREE_LSB  = 16;
   localparam int FREE_W    = 16;

   typedef enum logic {
      SEL_DATA = 1'b0,
      SEL_CTRL = 1'b1
   } con_reg_e;
endpackage

// File: rtl/con_fifo.sv
module con_fifo #(
   parameter int W  = 8,
   parameter int AW = 5
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic          full,
   output logic          empty,
   output logic [AW:0]   count
);
   localparam int DEPTH = 1 << AW;
   localparam int CW    = AW + 1;

   generate
      if (AW < 1 || AW > 15) begin : g_bad_aw
         $error("con_fifo: AW out of range");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign full    = (cnt == CW'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign dout    = mem[rp];
   assign count   = cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         cnt <= cnt + CW'(do_push) - CW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end
endmodule

// File: rtl/con_bus_slv.sv
module con_bus_slv
   import con_uart_pkg::*;
#(
   parameter int DW    = 32,
   parameter int CW    = 6,
   parameter int DEPTH = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cyc,
   input  logic              stb,
   input  logic              we,
   input  logic              adr,
   input  logic [DW-1:0]     wdat,
   input  logic [CW-1:0]     tx_count,
   input  logic              rx_empty,
   input  logic [CHAR_W-1:0] rx_dout,
   output logic [DW-1:0]     rdat,
   output logic              ack,
   output logic              tx_push,
   output logic [CHAR_W-1:0] tx_din,
   output logic              rx_pop
);
   logic              ack_q;
   logic [DW-1:0]     rdat_q;
   logic [DW-1:0]     rd_next;
   logic              acc;
   logic              sel_data;
   logic [FREE_W-1:0] free_cnt;

   assign acc      = cyc & stb & ~ack_q;
   assign sel_data = (con_reg_e'(adr) == SEL_DATA);
   assign free_cnt = FREE_W'(DEPTH - int'(tx_count));

   assign tx_push = acc & we & sel_data;
   assign tx_din  = wdat[CHAR_W-1:0];
   assign rx_pop  = acc & ~we & sel_data & ~rx_empty;

   always_comb begin
      rd_next = '0;
      if (sel_data) begin
         if (!rx_empty) begin
            rd_next[CHAR_W-1:0] = rx_dout;
            rd_next[VALID_BIT]  = 1'b1;
         end
      end else begin
         rd_next[FREE_LSB +: FREE_W] = free_cnt;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ack_q  <= 1'b0;
         rdat_q <= '0;
      end else begin
         ack_q <= acc;
         if (acc && !we) rdat_q <= rd_next;
      end
   end

   assign ack  = ack_q;
   assign rdat = rdat_q;
endmodule

// File: rtl/con_uart_regs.sv
module con_uart_regs
   import con_uart_pkg::*;
#(
   parameter int BUF_AW = 6,
   parameter int DW     = 32
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          bus_cyc,
   input  logic          bus_stb,
   input  logic          bus_we,
   input  logic          bus_adr,
   input  logic [DW-1:0] bus_wdat,
   output logic [DW-1:0] bus_rdat,
   output logic          bus_ack,
   output logic [7:0]    htx_data,
   output logic          htx_valid,
   input  logic          htx_ready,
   input  logic [7:0]    hrx_data,
   input  logic          hrx_wr,
   output logic          hrx_ready
);
   localparam int FIFO_AW = BUF_AW - 1;
   localparam int CW      = FIFO_AW + 1;
   localparam int DEPTH   = 1 << FIFO_AW;

   generate
      if (BUF_AW < 2 || BUF_AW > 16) begin : g_bad_buf
         $error("con_uart_regs: BUF_AW must lie in 2..16");
      end
      if (DW < FREE_LSB + FREE_W) begin : g_bad_dw
         $error("con_uart_regs: DW too narrow for free field");
      end
   endgenerate

   logic              tx_push, tx_full, tx_empty, tx_pop;
   logic [CHAR_W-1:0] tx_din;
   logic [CW-1:0]     tx_count;
   logic              rx_push, rx_pop, rx_full, rx_empty;
   logic [CHAR_W-1:0] rx_dout;
   logic [CW-1:0]     rx_count;

   assign htx_valid = ~tx_empty;
   assign tx_pop    = htx_valid & htx_ready;
   assign hrx_ready = ~rx_full;
   assign rx_push   = hrx_wr & hrx_ready;

   con_bus_slv #(.DW(DW), .CW(CW), .DEPTH(DEPTH)) u_bus (
      .clk      (clk),
      .rst      (rst),
      .cyc      (bus_cyc),
      .stb      (bus_stb),
      .we       (bus_we),
      .adr      (bus_adr),
      .wdat     (bus_wdat),
      .tx_count (tx_count),
      .rx_empty (rx_empty),
      .rx_dout  (rx_dout),
      .rdat     (bus_rdat),
      .ack      (bus_ack),
      .tx_push  (tx_push),
      .tx_din   (tx_din),
      .rx_pop   (rx_pop)
   );

   con_fifo #(.W(CHAR_W), .AW(FIFO_AW)) u_txq (
      .clk   (clk),
      .rst   (rst),
      .push  (tx_push),
      .din   (tx_din),
      .pop   (tx_pop),
      .dout  (htx_data),
      .full  (tx_full),
      .empty (tx_empty),
      .count (tx_count)
   );

   con_fifo #(.W(CHAR_W), .AW(FIFO_AW)) u_rxq (
      .clk   (clk),
      .rst   (rst),
      .push  (rx_push),
      .din   (hrx_data),
      .pop   (rx_pop),
      .dout  (rx_dout),
      .full  (rx_full),
      .empty (rx_empty),
      .count (rx_count)
   );
endmodule

// File: rtl/con_uart_regs_chk.sv
module con_uart_regs_chk #(
   parameter int DEPTH = 32,
   parameter int CW    = 6,
   parameter int DW    = 32
) (
   input logic          clk,
   input logic          rst,
   input logic          bus_cyc,
   input logic          bus_stb,
   input logic          bus_ack,
   input logic [DW-1:0] bus_rdat,
   input logic [7:0]    htx_data,
   input logic          htx_valid,
   input logic          htx_ready,
   input logic [CW-1:0] tx_cnt,
   input logic [CW-1:0] rx_cnt
);
   // R2
   ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      bus_ack |=> !bus_ack);

   // R2
   ack_req_chk: assert property (@(posedge clk) disable iff (rst)
      bus_ack |-> $past(bus_cyc && bus_stb));

   // R10
   htx_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (htx_valid && !htx_ready) |=> (htx_valid && $stable(htx_data)));

   // R8
   char_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_ack && !bus_rdat[15]) |-> (bus_rdat[7:0] == 8'h00));

   // R6
   tx_bound_chk: assert property (@(posedge clk) disable iff (rst)
      int'(tx_cnt) <= DEPTH);

   // R9
   rx_bound_chk: assert property (@(posedge clk) disable iff (rst)
      int'(rx_cnt) <= DEPTH);
endmodule

bind con_uart_regs con_uart_regs_chk #(.DEPTH(DEPTH), .CW(CW), .DW(DW)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .bus_cyc   (bus_cyc),
   .bus_stb   (bus_stb),
   .bus_ack   (bus_ack),
   .bus_rdat  (bus_rdat),
   .htx_data  (htx_data),
   .htx_valid (htx_valid),
   .htx_ready (htx_ready),
   .tx_cnt    (tx_count),
   .rx_cnt    (rx_count)
);

// File: tb/con_uart_regs_bench.sv
module con_uart_regs_bench;
   localparam int BUF_AW = 3;
   localparam int DEPTH  = 1 << (BUF_AW - 1);

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        bus_cyc = 1'b0, bus_stb = 1'b0, bus_we = 1'b0, bus_adr = 1'b0;
   logic [31:0] bus_wdat = '0;
   logic [31:0] bus_rdat;
   logic        bus_ack;
   logic [7:0]  htx_data;
   logic        htx_valid;
   logic        htx_ready = 1'b0;
   logic [7:0]  hrx_data = '0;
   logic        hrx_wr = 1'b0;
   logic        hrx_ready;

   int total = 0;
   int bad   = 0;
   int cycles = 0;
   logic sink_on = 1'b0;
   logic slow = 1'b0;
   logic tog = 1'b0;
   int tx_model = 0;
   int rx_model = 0;
   logic [7:0] txq[$];
   logic [7:0] rxq[$];

   always #10 clk = ~clk;

   con_uart_regs #(.BUF_AW(BUF_AW), .DW(32)) u_con_uart_regs (
      .clk(clk), .rst(rst),
      .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we), .bus_adr(bus_adr),
      .bus_wdat(bus_wdat), .bus_rdat(bus_rdat), .bus_ack(bus_ack),
      .htx_data(htx_data), .htx_valid(htx_valid), .htx_ready(htx_ready),
      .hrx_data(hrx_data), .hrx_wr(hrx_wr), .hrx_ready(hrx_ready)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         total++;
         bad++;
         $display("FAIL R2 watchdog actual=hung expected=done");
         summary();
         $finish;
      end
   end

   // monitor: decides ready for the coming edge, compares the handshaken char
   always @(negedge clk) begin
      tog = ~tog;
      htx_ready = sink_on && (!slow || tog);
      if (htx_valid && htx_ready) begin
         if (txq.size() == 0) begin
            chk("R10 unexpected char", {24'h0, htx_data}, 32'hxxxxxxxx);
         end else begin
            chk("R4 tx order", {24'h0, htx_data}, {24'h0, txq.pop_front()});
         end
      end
   end

   task automatic bus_xfer(input logic we, input logic adr, input logic [31:0] wd,
                           output logic [31:0] rd);
      @(negedge clk);
      bus_cyc = 1'b1; bus_stb = 1'b1; bus_we = we; bus_adr = adr; bus_wdat = wd;
      @(negedge clk);
      chk("R2 ack one cycle after request", {31'h0, bus_ack}, 32'h1);
      rd = bus_rdat;
      bus_cyc = 1'b0; bus_stb = 1'b0;
      @(negedge clk);
      chk("R2 ack single cycle", {31'h0, bus_ack}, 32'h0);
   endtask

   // driver: writes a char and records what should leave the transmit side
   task automatic wr_data(input logic [31:0] wd);
      logic [31:0] rd;
      if (tx_model < DEPTH) begin
         txq.push_back(wd[7:0]);
         tx_model++;
      end
      bus_xfer(1'b1, 1'b0, wd, rd);
   endtask

   task automatic rd_ctrl(input string tag);
      logic [31:0] rd;
      bus_xfer(1'b0, 1'b1, 32'h0, rd);
      chk(tag, rd, (32'(DEPTH - tx_model)) << 16);
   endtask

   task automatic rd_data(input string tag);
      logic [31:0] rd;
      logic [31:0] exp;
      exp = '0;
      if (rxq.size() > 0) begin
         exp = {16'h0, 1'b1, 7'h0, rxq.pop_front()};
         rx_model--;
      end
      bus_xfer(1'b0, 1'b0, 32'h0, rd);
      chk(tag, rd, exp);
   endtask

   task automatic inject(input logic [7:0] b);
      logic exp_rdy;
      @(negedge clk);
      exp_rdy = (rx_model < DEPTH);
      chk("R9 inject ready", {31'h0, hrx_ready}, {31'h0, exp_rdy});
      hrx_data = b;
      hrx_wr = 1'b1;
      if (exp_rdy) begin
         rxq.push_back(b);
         rx_model++;
      end
      @(negedge clk);
      hrx_wr = 1'b0;
   endtask

   task automatic drain(input string tag);
      @(posedge clk);
      sink_on = 1'b1;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (!htx_valid && txq.size() == 0) break;
      end
      @(posedge clk);
      sink_on = 1'b0;
      tx_model = 0;
      chk(tag, txq.size(), 0);
   endtask

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk("R1 ack low after reset", {31'h0, bus_ack}, 32'h0);
      chk("R1 htx_valid low after reset", {31'h0, htx_valid}, 32'h0);
      chk("R1 hrx_ready high after reset", {31'h0, hrx_ready}, 32'h1);
      rd_ctrl("R1 R5 R3 ctrl free after reset");
      rd_data("R1 R8 data empty after reset");

      // transmit fill with sink stopped
      wr_data(32'hABCD_EF41);
      rd_ctrl("R5 free after one write");
      repeat (4) @(negedge clk);
      chk("R10 head held without ready", {24'h0, htx_data}, 32'h41);
      chk("R10 valid held without ready", {31'h0, htx_valid}, 32'h1);
      wr_data(32'h0000_0142);
      wr_data(32'hFFFF_FF43);
      wr_data(32'h0000_0044);
      rd_ctrl("R11 R6 free zero after depth writes");
      wr_data(32'h0000_0099);
      rd_ctrl("R6 free still zero after dropped write");
      bus_xfer(1'b1, 1'b1, 32'h0000_0055, rd);
      rd_ctrl("R12 ctrl write while full no effect");
      drain("R4 R6 R12 all chars drained");
      rd_ctrl("R5 free back to depth");

      // control write with empty tx
      bus_xfer(1'b1, 1'b1, 32'hFFFF_FF66, rd);
      @(negedge clk);
      chk("R12 ctrl write queues nothing", {31'h0, htx_valid}, 32'h0);
      rd_ctrl("R12 free unchanged after ctrl write");

      // receive path
      inject(8'h10);
      inject(8'h20);
      rd_data("R7 first rx char");
      rd_data("R7 second rx char");
      rd_data("R8 empty read");
      rd_data("R8 second empty read");
      inject(8'h30);
      rd_data("R8 R7 read after empty reads");

      // receive fill beyond depth
      for (int i = 0; i < DEPTH + 1; i++) inject(8'hA0 + 8'(i));
      @(negedge clk);
      chk("R9 ready low when full", {31'h0, hrx_ready}, 32'h0);
      for (int i = 0; i < DEPTH; i++) rd_data("R7 R9 rx fill order");
      rd_data("R8 rx empty after fill");
      @(negedge clk);
      chk("R9 ready back after reads", {31'h0, hrx_ready}, 32'h1);

      // throttled sink
      @(posedge clk);
      slow = 1'b1;
      sink_on = 1'b1;
      wr_data(32'h0000_0071);
      wr_data(32'h0000_0072);
      wr_data(32'h0000_0073);
      drain("R10 throttled drain");
      slow = 1'b0;

      // reset mid-traffic
      wr_data(32'h0000_0081);
      inject(8'h82);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      txq.delete();
      rxq.delete();
      tx_model = 0;
      rx_model = 0;
      @(negedge clk);
      chk("R1 reset empties tx", {31'h0, htx_valid}, 32'h0);
      rd_data("R1 reset empties rx");
      rd_ctrl("R1 reset restores free");

      repeat (3) @(negedge clk);
      summary();
      $finish;
   end
endmodule